// File: doc/BRIEF.md
# Single-Row SDRAM Burst Data Engine

This block is a synthesizable device-side model of the data path of a synchronous DRAM with one row already open. The row holds a small array of columns. A host sends read and write commands with a starting column. The block then moves a burst of words through the row: write words are taken on the host data input, and read words come back on a data output with its own output enable, which drives a tristate pad outside the block. The burst length and the CAS latency are loaded through a mode input. A per-cycle mask input blanks read words or blocks write words.

A burst steps through adjacent columns. When the start column is not aligned to the burst length, the burst wraps inside its aligned block. A read or write command that arrives during a burst ends that burst and starts the new one at once. In full-page mode a burst runs around the whole row until a stop command or a new command arrives. In every other length the stop command has no effect.

Top module: `burst_row_dev`

## Requirements
- R1: After reset, dq_oe_o is low, the burst length is 1 and the CAS latency is 2.
- R2: Commands on cmd_i are NOP=00, READ=01, WRITE=10, STOP=11. The first read word is driven with dq_oe_o high during the clock period that ends at the CL-th rising edge after the edge that samples READ. The following words come on consecutive periods.
- R3: Beat k of a burst of length L that starts at column s uses column (s with its low log2(L) bits cleared) + ((s + k) mod L).
- R4: A write captures dq_i into the start column at the edge that samples WRITE, and into the next column of the sequence at each later edge. Capture stops after L beats.
- R5: dqm_i high at edge e drops dq_oe_o for the single period that ends at edge e+2. That read word is consumed and not delayed.
- R6: dqm_i high at the edge of a write beat blocks only that beat, so the column keeps its old contents.
- R7: dq_oe_o goes low in the period after the last read word. A READ sampled exactly L edges after the previous one continues the output with no gap.
- R8: A READ or WRITE sampled during a burst ends that burst. The new burst starts at its own column and uses the R3 order.
- R9: From the edge that samples WRITE, dq_oe_o stays low, and read words still waiting in the latency pipeline never appear.
- R10: In full-page mode, STOP ends the burst: the STOP cycle and later cycles produce no beat. In any other length, STOP is ignored.
- R11: In full-page mode, the burst length is the column count of the row, and a burst wraps from the last column to column 0 without ending.
- R12: When mode_ld_i is high, mode_bl_i codes 0,1,2,3,7 select lengths 1,2,4,8 and full page, and mode_cl_i 0/1 selects latency 2/3. The load takes effect only with cmd_i=NOP, no burst active and no read word pending. An unlisted length code ignores the whole load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Command code: NOP, READ, WRITE, STOP |
| col_i | input | COL_W | Start column, sampled with READ or WRITE |
| mode_ld_i | input | 1 | Mode load request |
| mode_bl_i | input | 3 | Burst length code for a mode load |
| mode_cl_i | input | 1 | CAS latency select for a mode load (0: 2, 1: 3) |
| dqm_i | input | 1 | Data mask |
| dq_i | input | DW | Write data from the pad |
| dq_o | output | DW | Read data to the pad |
| dq_oe_o | output | 1 | Pad output enable |

## Verification
The hardest state to reach is a write that arrives while read words are still in flight in the latency pipeline. The read must have started, and the WRITE must land after the first words have come out but before the later ones would. The stimulus therefore issues a length-8 read and places the WRITE exactly three edges later, then watches the enable for the whole write burst. It then reads the row back to confirm the columns that were written. Full-page wrap and stop get the same treatment: a write runs past the last column into column 0, and a STOP carries a distinct data word that must not land in the row.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
package burst_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_RD   = 2'b01,
    CMD_WR   = 2'b10,
    CMD_STOP = 2'b11
  } cmd_e;

  // burst length codes accepted by a mode load
  localparam logic [2:0] BLC_1    = 3'd0;
  localparam logic [2:0] BLC_2    = 3'd1;
  localparam logic [2:0] BLC_4    = 3'd2;
  localparam logic [2:0] BLC_8    = 3'd3;
  localparam logic [2:0] BLC_FULL = 3'd7;

  // largest latency is 3: internal stages before the output register
  localparam int CL_STAGES = 2;

endpackage

// File: rtl/burst_seq.sv
`timescale 1ns/1ps
module burst_seq
  import burst_pkg::*;
#(
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] len_m1,
  input  logic             full,
  output logic             beat_v,
  output logic             beat_wr,
  output logic [COL_W-1:0] beat_col,
  output logic             busy
);

  logic             act_q, act_d;
  logic             wr_q, wr_d;
  logic [COL_W-1:0] start_q, start_d;
  logic [COL_W-1:0] k_q, k_d;
  logic             new_cmd, stop_hit, seq_en;

  assign new_cmd  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign stop_hit = (cmd == CMD_STOP) && full && act_q;
  assign seq_en   = new_cmd || act_q;
  assign busy     = act_q;

  // beat issued in the current cycle
  always_comb begin
    beat_v   = 1'b0;
    beat_wr  = wr_q;
    beat_col = col_i;
    if (new_cmd) begin
      beat_v  = 1'b1;
      beat_wr = (cmd == CMD_WR);
    end else if (act_q && !stop_hit) begin
      beat_v   = 1'b1;
      beat_col = (start_q & ~len_m1) | ((start_q + k_q) & len_m1);
    end
  end

  always_comb begin
    act_d   = act_q;
    wr_d    = wr_q;
    start_d = start_q;
    k_d     = k_q;
    if (new_cmd) begin
      act_d   = (len_m1 != '0);
      wr_d    = (cmd == CMD_WR);
      start_d = col_i;
      k_d     = COL_W'(1);
    end else if (stop_hit) begin
      act_d = 1'b0;
    end else if (act_q) begin
      if (!full && (k_q == len_m1)) act_d = 1'b0;
      k_d = k_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      start_q <= '0;
      k_q     <= '0;
    end else if (seq_en) begin
      act_q   <= act_d;
      wr_q    <= wr_d;
      start_q <= start_d;
      k_q     <= k_d;
    end
  end

  // R3: a bounded burst never counts past its length
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !full) |-> (k_q != '0 && k_q <= len_m1))
    else $error("R3: beat counter out of burst");

endmodule

// File: rtl/row_store.sv
`timescale 1ns/1ps
module row_store #(
  parameter int DW    = 8,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [COL_W-1:0] wcol,
  input  logic [DW-1:0]    wdata,
  input  logic [COL_W-1:0] rcol,
  output logic [DW-1:0]    rdata
);

  localparam int NCOL = 1 << COL_W;

  logic [DW-1:0] cells [NCOL];

  always_ff @(posedge clk) begin
    if (we) cells[wcol] <= wdata;
  end

  assign rdata = cells[rcol];

endmodule

// File: rtl/rd_pipe.sv
`timescale 1ns/1ps
module rd_pipe #(
  parameter int DW     = 8,
  parameter int STAGES = 2,
  localparam int TAP_W = $clog2(STAGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    push_d,
  input  logic             flush,
  input  logic             dqm,
  input  logic [TAP_W-1:0] tap,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe,
  output logic             pend
);

  logic          v   [1:STAGES];
  logic [DW-1:0] d   [1:STAGES];
  logic          v_d [1:STAGES];
  logic [DW-1:0] d_d [1:STAGES];
  logic          dqm_q, oe_q, oe_d, tap_v;
  logic [DW-1:0] o_q, tap_d;

  always_comb begin
    v_d[1] = push;
    d_d[1] = push_d;
    for (int s = 2; s <= STAGES; s++) begin
      v_d[s] = v[s-1];
      d_d[s] = d[s-1];
    end
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v[s] <= 1'b0;
        d[s] <= '0;
      end else begin
        v[s] <= v_d[s] && !flush;
        if (v_d[s]) d[s] <= d_d[s];
      end
    end
  end

  always_comb begin
    tap_v = v[tap];
    tap_d = d[tap];
    oe_d  = tap_v && !dqm_q && !flush;
    pend  = oe_q;
    for (int s = 1; s <= STAGES; s++) pend = pend | v[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dqm_q <= 1'b0;
      oe_q  <= 1'b0;
      o_q   <= '0;
    end else begin
      dqm_q <= dqm;
      oe_q  <= oe_d;
      if (tap_v) o_q <= tap_d;
    end
  end

  assign dq_o  = o_q;
  assign dq_oe = oe_q;

  // R5: the driver only turns on for a word that travelled the pipeline
  a_r5_oe_from_stage: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(v[1] || v[STAGES]))
    else $error("R5: enable without a pending word");

  // R9: a write empties the pipeline and the driver
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pend)
    else $error("R9: read words survived a write");

endmodule

// File: rtl/burst_row_dev.sv
`timescale 1ns/1ps
module burst_row_dev
  import burst_pkg::*;
#(
  parameter int DW    = 8,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             mode_ld_i,
  input  logic [2:0]       mode_bl_i,
  input  logic             mode_cl_i,
  input  logic             dqm_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o
);

  localparam int TAP_W = $clog2(CL_STAGES + 1);

  cmd_e             cmd;
  logic             beat_v, beat_wr, seq_busy, pipe_busy;
  logic [COL_W-1:0] beat_col;
  logic [DW-1:0]    rd_word;
  logic [COL_W-1:0] len_m1_q, dec_len;
  logic             full_q, cl3_q, dec_full, bl_ok, mode_en;
  logic [TAP_W-1:0] tap;

  assign cmd = cmd_e'(cmd_i);

  always_comb begin
    bl_ok    = 1'b1;
    dec_full = 1'b0;
    dec_len  = '0;
    case (mode_bl_i)
      BLC_1:    dec_len = '0;
      BLC_2:    dec_len = COL_W'(1);
      BLC_4:    dec_len = COL_W'(3);
      BLC_8:    dec_len = COL_W'(7);
      BLC_FULL: begin dec_len = '1; dec_full = 1'b1; end
      default:  bl_ok = 1'b0;
    endcase
    mode_en = mode_ld_i && bl_ok && (cmd == CMD_NOP) && !seq_busy && !pipe_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_m1_q <= '0;
      full_q   <= 1'b0;
      cl3_q    <= 1'b0;
    end else if (mode_en) begin
      len_m1_q <= dec_len;
      full_q   <= dec_full;
      cl3_q    <= mode_cl_i;
    end
  end

  assign tap = cl3_q ? TAP_W'(2) : TAP_W'(1);

  burst_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .col_i(col_i),
    .len_m1(len_m1_q), .full(full_q),
    .beat_v(beat_v), .beat_wr(beat_wr), .beat_col(beat_col), .busy(seq_busy)
  );

  row_store #(.DW(DW), .COL_W(COL_W)) u_row (
    .clk(clk), .we(beat_v && beat_wr && !dqm_i), .wcol(beat_col),
    .wdata(dq_i), .rcol(beat_col), .rdata(rd_word)
  );

  rd_pipe #(.DW(DW), .STAGES(CL_STAGES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .push(beat_v && !beat_wr), .push_d(rd_word),
    .flush(cmd == CMD_WR), .dqm(dqm_i), .tap(tap),
    .dq_o(dq_o), .dq_oe(dq_oe_o), .pend(pipe_busy)
  );

  // R9: no read word is driven after a write command
  a_r9_quiet_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'b10) |=> !dq_oe_o)
    else $error("R9: output enabled after write");

  // R12: the mode only changes from an idle state
  a_r12_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({len_m1_q, full_q, cl3_q}) |-> $past(!seq_busy && !pipe_busy))
    else $error("R12: mode changed during a burst");

endmodule

// File: tb/burst_row_dev_test.sv
`timescale 1ns/1ps
module burst_row_dev_test;

  localparam int DW = 8;
  localparam int COL_W = 4;
  localparam int NCOL = 16;
  localparam logic [1:0] NOP = 2'b00, RD = 2'b01, WR = 2'b10, STP = 2'b11;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cmd;
  logic [COL_W-1:0] col;
  logic mode_ld, mode_cl, dqm;
  logic [2:0] mode_bl;
  logic [DW-1:0] din, dout;
  logic doe;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [DW-1:0] refm [NCOL];

  always #2.5 clk = ~clk;

  burst_row_dev #(.DW(DW), .COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .col_i(col),
    .mode_ld_i(mode_ld), .mode_bl_i(mode_bl), .mode_cl_i(mode_cl),
    .dqm_i(dqm), .dq_i(din), .dq_o(dout), .dq_oe_o(doe)
  );

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int bc(int s, int k, int len);
    return (s & ~(len - 1)) | ((s + k) & (len - 1));
  endfunction

  task automatic chk_beat(string req, logic eoe, logic [DW-1:0] ed);
    n_chk++;
    if (doe !== eoe || (eoe && dout !== ed)) begin
      n_bad++;
      $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h", req, doe, dout, eoe, ed);
    end
  endtask

  task automatic set_mode(int blc, int clc);
    mode_ld = 1'b1; mode_bl = 3'(blc); mode_cl = clc[0];
    tick;
    mode_ld = 1'b0;
  endtask

  task automatic read_check(string req, int s, int len, int cl);
    cmd = RD; col = COL_W'(s);
    tick;
    cmd = NOP;
    for (int i = 0; i < cl - 1; i++) begin
      chk_beat(req, 1'b0, '0);
      tick;
    end
    for (int k = 0; k < len; k++) begin
      chk_beat(req, 1'b1, refm[bc(s, k, len)]);
      tick;
    end
    chk_beat(req, 1'b0, '0);
  endtask

  task automatic write_burst(int s, int len, int base, int mask_k);
    for (int k = 0; k < len; k++) begin
      cmd = (k == 0) ? WR : NOP;
      col = COL_W'(s);
      din = DW'(base + k);
      dqm = (k == mask_k);
      tick;
      if (k != mask_k) refm[bc(s, k, len)] = DW'(base + k);
    end
    cmd = NOP; dqm = 1'b0;
  endtask

  // R1 R2 R4: defaults after reset
  task automatic t_reset_defaults;
    chk_beat("R1 enable after reset", 1'b0, '0);
    write_burst(2, 1, 'hA2, -1);
    din = 8'h5A;
    tick;
    read_check("R1 R2 default BL1 CL2", 2, 1, 2);
  endtask

  // R10 R11 R3: full-page write wrapping and stop
  task automatic t_full_page_write;
    set_mode(7, 0);
    write_burst(0, NCOL, 'h10, -1);
    din = 8'h30; tick; refm[0] = 8'h30;
    din = 8'h31; tick; refm[1] = 8'h31;
    cmd = STP; din = 8'hEE; tick;
    cmd = NOP; din = 8'hDD; tick;
    set_mode(3, 1);
    read_check("R3 R10 R11 block 0", 5, 8, 3);
    read_check("R3 R11 block 1", 12, 8, 3);
  endtask

  // R4 R6: masked write beat and end of capture
  task automatic t_masked_write;
    set_mode(2, 0);
    write_burst(10, 4, 'h80, 2);
    din = 8'h55;
    tick;
    read_check("R4 R6 masked beat", 8, 4, 2);
  endtask

  // R5: read mask two cycles later
  task automatic t_read_mask;
    cmd = RD; col = 4'd8; tick; cmd = NOP;
    chk_beat("R5 before data", 1'b0, '0);
    dqm = 1'b1; tick; dqm = 1'b0;
    chk_beat("R5 beat0", 1'b1, refm[8]);
    tick; chk_beat("R5 beat1 masked", 1'b0, '0);
    tick; chk_beat("R5 beat2", 1'b1, refm[10]);
    tick; chk_beat("R5 beat3", 1'b1, refm[11]);
    tick; chk_beat("R5 end", 1'b0, '0);
  endtask

  // R7 R8: gapless and interrupting reads
  task automatic t_read_chain;
    set_mode(1, 1);
    cmd = RD; col = 4'd0; tick;
    cmd = NOP; tick;
    cmd = RD; col = 4'd5; tick; cmd = NOP;
    chk_beat("R7 first", 1'b1, refm[0]);
    tick; chk_beat("R7 second", 1'b1, refm[1]);
    tick; chk_beat("R7 gapless", 1'b1, refm[5]);
    tick; chk_beat("R7 wrap", 1'b1, refm[4]);
    tick; chk_beat("R7 end", 1'b0, '0);
    set_mode(3, 0);
    cmd = RD; col = 4'd0; tick;
    cmd = NOP; tick;
    chk_beat("R8 beat0", 1'b1, refm[0]);
    cmd = RD; col = 4'd12; tick; cmd = NOP;
    chk_beat("R8 beat1", 1'b1, refm[1]);
    for (int k = 0; k < 8; k++) begin
      tick; chk_beat("R8 new burst", 1'b1, refm[bc(12, k, 8)]);
    end
    tick; chk_beat("R8 end", 1'b0, '0);
  endtask

  // R9: write interrupts a read
  task automatic t_write_over_read;
    cmd = RD; col = 4'd0; tick; cmd = NOP;
    tick; chk_beat("R9 pre beat0", 1'b1, refm[0]);
    tick; chk_beat("R9 pre beat1", 1'b1, refm[1]);
    for (int k = 0; k < 8; k++) begin
      cmd = (k == 0) ? WR : NOP; col = 4'd4; din = DW'('h40 + k);
      tick;
      refm[bc(4, k, 8)] = DW'('h40 + k);
      chk_beat("R9 driver off", 1'b0, '0);
    end
    cmd = NOP;
    tick; chk_beat("R9 driver off tail", 1'b0, '0);
    read_check("R8 R9 written row", 4, 8, 2);
  endtask

  // R10 R11: stop ignored and honoured
  task automatic t_stop;
    set_mode(2, 0);
    cmd = RD; col = 4'd1; tick;
    chk_beat("R10 lead", 1'b0, '0);
    cmd = STP; tick; cmd = NOP;
    for (int k = 0; k < 4; k++) begin
      chk_beat("R10 ignored stop", 1'b1, refm[bc(1, k, 4)]);
      tick;
    end
    chk_beat("R10 end", 1'b0, '0);
    set_mode(7, 0);
    cmd = RD; col = 4'd14; tick; cmd = NOP;
    chk_beat("R11 lead", 1'b0, '0);
    tick; chk_beat("R11 col14", 1'b1, refm[14]);
    tick; chk_beat("R11 col15", 1'b1, refm[15]);
    tick; chk_beat("R11 wrap col0", 1'b1, refm[0]);
    cmd = STP; tick; cmd = NOP;
    chk_beat("R10 last before stop", 1'b1, refm[1]);
    tick; chk_beat("R10 stopped", 1'b0, '0);
    tick; chk_beat("R10 stays off", 1'b0, '0);
  endtask

  // R12: mode load rules
  task automatic t_mode_rules;
    set_mode(3, 0);
    cmd = RD; col = 4'd0; tick; cmd = NOP;
    chk_beat("R12 lead", 1'b0, '0);
    mode_ld = 1'b1; mode_bl = 3'd0; mode_cl = 1'b1;
    tick; mode_ld = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk_beat("R12 busy load ignored", 1'b1, refm[k]);
      tick;
    end
    chk_beat("R12 end", 1'b0, '0);
    set_mode(5, 1);
    read_check("R12 bad code ignored", 3, 8, 2);
    tick;
    set_mode(0, 1);
    read_check("R12 idle load BL1 CL3", 3, 1, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd = NOP; col = '0; mode_ld = 1'b0; mode_bl = '0;
    mode_cl = 1'b0; dqm = 1'b0; din = '0;
    for (int i = 0; i < NCOL; i++) refm[i] = '0;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    t_reset_defaults;
    t_full_page_write;
    t_masked_write;
    t_read_mask;
    t_read_chain;
    t_write_over_read;
    t_stop;
    t_mode_rules;
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule